// File: doc/BRIEF.md
# Programmable Tick Timer

This block is a 32-bit tick counter paired with a configuration register. Together they raise a timer interrupt when the counter reaches a programmed period. A clock-enable input (`tick_en`) paces the counter. The configuration register chooses one of four modes: off, wrap to zero on a match, stop on a match, or count straight through a match. It also holds the 28-bit period, an interrupt enable and a pending flag.

Software reaches the block through a single-cycle write/read port with two addresses: configuration and counter. Reads are combinational and return live state. The pending flag can only be set by the hardware. Software can keep it or clear it, but never set it. Counting starts or stops only on a write that actually changes the mode field.

Top module: `tick_timer`

## Requirements
- R1: After reset the configuration register reads 0, the counter reads 0, `irq` is low and the counter is stopped.
- R2: Address 0 selects the configuration register and address 1 selects the counter. A write to address 1 loads all 32 counter bits, and reading either address returns its current value.
- R3: The configuration layout is mode[31:30], irq enable[29], pending[28] and period[27:0]. Mode codes are 0 off, 1 restart, 2 one-shot and 3 continuous. A write that changes the mode to off stops counting, and a write that changes it to any other code starts counting.
- R4: A configuration write whose mode equals the stored mode leaves the counter's running state as it was. For example, a stopped one-shot timer stays stopped.
- R5: While running, the counter advances by one on every cycle with `tick_en` high and wraps from 0xFFFFFFFF to 0. Otherwise it holds its value.
- R6: A match happens on a counting tick when counter bits 27:0 equal the period. Match checking starts from a freshly loaded value. In restart mode a match returns the counter to 0.
- R7: In one-shot mode a match stops counting, and the counter holds the matched value.
- R8: In continuous mode the counter keeps incrementing through a match.
- R9: A match sets the pending flag only when the irq enable bit is 1.
- R10: Writing pending=1 keeps the stored pending value. Writing pending=0 clears it. Software can never set it.
- R11: `irq` is high exactly when both the pending flag and the irq enable bit are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = configuration, 1 = counter |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the selected register |
| tick_en | input | 1 | Counter clock enable |
| irq | output | 1 | Timer interrupt |

## Verification
Most internal faults reach the ports immediately. A bad running flag, a wrong match decision or a wrong counter step shows up on the counter readback after the first tick that follows it. A pending flag that is set or cleared wrongly shows on `irq` and in bit 28 of the configuration readback in the next cycle. Each test runs the counter for an exact number of enabled ticks and then freezes it, so every count readback has a single expected value. The runs are arranged so that a one-shot stop, a restart wrap, an unchanged-mode write and a stray software set of the pending flag each leave a different value behind.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

    localparam int TT_DW = 32;
    localparam int TT_PW = 28;

    typedef enum logic [1:0] {
        TMODE_OFF     = 2'd0,
        TMODE_RESTART = 2'd1,
        TMODE_ONESHOT = 2'd2,
        TMODE_CONT    = 2'd3
    } tmode_e;

    // Packed so that the field order gives the register layout
    typedef struct packed {
        tmode_e             mode;
        logic               irq_en;
        logic               pend;
        logic [TT_PW-1:0]   period;
    } tcfg_t;

    typedef enum logic {
        TADDR_CFG = 1'b0,
        TADDR_CNT = 1'b1
    } taddr_e;

    function automatic logic mode_runs(tmode_e m);
        return m != TMODE_OFF;
    endfunction

    function automatic logic low_match(logic [TT_DW-1:0] c, logic [TT_PW-1:0] p);
        return c[TT_PW-1:0] == p;
    endfunction

endpackage

// File: rtl/tt_cfg_reg.sv
module tt_cfg_reg
    import tick_timer_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   we,
    input  tcfg_t  wdata,
    input  logic   match_evt,
    output tcfg_t  cfg,
    output logic   run
);

    logic pend_keep;
    logic pend_next;
    logic run_next;
    logic mode_chg;

    assign mode_chg  = we && (wdata.mode != cfg.mode);
    assign pend_keep = we ? (wdata.pend & cfg.pend) : cfg.pend;
    assign pend_next = pend_keep | (match_evt & cfg.irq_en);

    always_comb begin
        run_next = run;
        if (match_evt && cfg.mode == TMODE_ONESHOT)
            run_next = 1'b0;
        if (mode_chg)
            run_next = mode_runs(wdata.mode);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
            run <= 1'b0;
        end else begin
            if (we) begin
                cfg.mode   <= wdata.mode;
                cfg.irq_en <= wdata.irq_en;
                cfg.period <= wdata.period;
            end
            cfg.pend <= pend_next;
            run      <= run_next;
        end
    end

    assert_pend_only_hw_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(cfg.pend) |-> $past(match_evt));

    assert_pend_clear_R10: assert property (@(posedge clk) disable iff (rst)
        (we && !wdata.pend && !match_evt) |=> !cfg.pend);

    assert_same_mode_run_R4: assert property (@(posedge clk) disable iff (rst)
        (we && wdata.mode == cfg.mode && !match_evt) |=> run == $past(run));

    assert_off_stops_R3: assert property (@(posedge clk) disable iff (rst)
        (we && wdata.mode == TMODE_OFF) |=> !run);

endmodule

// File: rtl/tt_counter.sv
module tt_counter
    import tick_timer_pkg::*;
#(
    parameter int DW = TT_DW,
    parameter int PW = TT_PW
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           tick,
    input  logic           run,
    input  tmode_e         mode,
    input  logic [PW-1:0]  period,
    input  logic           load,
    input  logic [DW-1:0]  load_val,
    output logic [DW-1:0]  cnt,
    output logic           match_evt
);

    localparam logic [DW-1:0] ONE = DW'(1);

    assign match_evt = run && tick && (cnt[PW-1:0] == period);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (run && tick) begin
            if (match_evt && mode == TMODE_RESTART)
                cnt <= '0;
            else if (!(match_evt && mode == TMODE_ONESHOT))
                cnt <= cnt + ONE;
        end
    end

    assert_restart_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (match_evt && mode == TMODE_RESTART && !load) |=> cnt == '0);

    assert_oneshot_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (match_evt && mode == TMODE_ONESHOT && !load) |=> $stable(cnt));

    assert_cont_step_R8: assert property (@(posedge clk) disable iff (rst)
        (run && tick && mode == TMODE_CONT && !load) |=> cnt == $past(cnt) + ONE);

    assert_idle_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (!(run && tick) && !load) |=> $stable(cnt));

    assert_load_R2: assert property (@(posedge clk) disable iff (rst)
        load |=> cnt == $past(load_val));

endmodule

// File: rtl/tick_timer.sv
module tick_timer
    import tick_timer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic              reg_addr,
    input  logic [TT_DW-1:0]  reg_wdata,
    output logic [TT_DW-1:0]  reg_rdata,
    input  logic              tick_en,
    output logic              irq
);

    tcfg_t            cfg;
    logic             run;
    logic             match_evt;
    logic [TT_DW-1:0] cnt;
    logic             cfg_we;
    logic             cnt_we;
    taddr_e           sel;

    assign sel    = taddr_e'(reg_addr);
    assign cfg_we = reg_we && sel == TADDR_CFG;
    assign cnt_we = reg_we && sel == TADDR_CNT;

    tt_cfg_reg u_cfg (
        .clk       (clk),
        .rst       (rst),
        .we        (cfg_we),
        .wdata     (tcfg_t'(reg_wdata)),
        .match_evt (match_evt),
        .cfg       (cfg),
        .run       (run)
    );

    tt_counter #(.DW(TT_DW), .PW(TT_PW)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick_en),
        .run       (run),
        .mode      (cfg.mode),
        .period    (cfg.period),
        .load      (cnt_we),
        .load_val  (reg_wdata),
        .cnt       (cnt),
        .match_evt (match_evt)
    );

    assign reg_rdata = (sel == TADDR_CNT) ? cnt : TT_DW'(cfg);
    assign irq       = cfg.pend & cfg.irq_en;

    assert_irq_drop_R11: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && !reg_wdata[TT_PW+1]) |=> !irq);

endmodule

// File: tb/tick_timer_tb_top.sv
module tick_timer_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        reg_we;
    logic        reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        tick_en;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    typedef struct {
        bit          is_irq;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sb_q[$];

    always #10 clk = ~clk;

    tick_timer dut_i (
        .clk       (clk),
        .rst       (rst),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .tick_en   (tick_en),
        .irq       (irq)
    );

    // Monitor: compares mid-cycle, after the edge has settled
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (sb_q.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it  = sb_q.pop_front();
                act = it.is_irq ? {31'b0, irq} : reg_rdata;
                checks++;
                if (act !== it.exp) begin
                    fails++;
                    $display("FAIL %s: actual 0x%08h expected 0x%08h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic wr(input logic a, input logic [31:0] d);
        reg_we    = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        @(negedge clk);
        reg_we    = 1'b0;
    endtask

    task automatic ticks(input int n);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic exp_rd(input logic a, input logic [31:0] v, input string tag);
        item_t it;
        reg_addr = a;
        it.is_irq = 1'b0;
        it.exp    = v;
        it.tag    = tag;
        sb_q.push_back(it);
        @(negedge clk);
    endtask

    task automatic exp_irq(input logic v, input string tag);
        item_t it;
        it.is_irq = 1'b1;
        it.exp    = {31'b0, v};
        it.tag    = tag;
        sb_q.push_back(it);
        @(negedge clk);
    endtask

    initial begin
        #(20 * 50000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; reg_we = 1'b0; reg_addr = 1'b0; reg_wdata = '0; tick_en = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        exp_rd(1'b0, 32'h0, "R1 cfg reset");
        exp_rd(1'b1, 32'h0, "R1 count reset");
        exp_irq(1'b0, "R1 irq reset");
        ticks(5);
        exp_rd(1'b1, 32'h0, "R1 stopped after reset");

        wr(1'b1, 32'h0000_0ABC);
        exp_rd(1'b1, 32'h0000_0ABC, "R2 count load");
        ticks(3);
        exp_rd(1'b1, 32'h0000_0ABC, "R5 off holds");
        wr(1'b1, 32'h0);

        // continuous, irq enabled, period 5; pending=1 written must not set it
        wr(1'b0, 32'hF000_0005);
        ticks(4);
        exp_rd(1'b1, 32'd4, "R5 count steps");
        exp_rd(1'b0, 32'hE000_0005, "R10 sw cannot set pend");
        exp_irq(1'b0, "R9 no match yet");
        ticks(2);
        exp_rd(1'b1, 32'd6, "R8 through match");
        exp_irq(1'b1, "R9 pend on match");
        exp_rd(1'b0, 32'hF000_0005, "R9 pend bit read");

        wr(1'b0, 32'hF000_0005);
        exp_irq(1'b1, "R10 write 1 keeps");
        wr(1'b0, 32'hD000_0005);
        exp_rd(1'b0, 32'hD000_0005, "R11 pend kept ie off");
        exp_irq(1'b0, "R11 gated by enable");
        wr(1'b0, 32'hF000_0005);
        exp_irq(1'b1, "R11 enable restores");
        wr(1'b0, 32'hE000_0005);
        exp_irq(1'b0, "R10 write 0 clears");
        exp_rd(1'b0, 32'hE000_0005, "R10 cleared read");
        exp_rd(1'b1, 32'd6, "R4 no ticks no change");

        // restart, period 3
        wr(1'b1, 32'h0);
        wr(1'b0, 32'h7000_0003);
        ticks(4);
        exp_rd(1'b1, 32'd0, "R6 restart wraps");
        exp_irq(1'b1, "R6 restart pend");
        ticks(2);
        exp_rd(1'b1, 32'd2, "R6 after wrap");

        wr(1'b0, 32'h4000_0003);
        ticks(2);
        exp_rd(1'b1, 32'd0, "R6 second wrap");
        exp_irq(1'b0, "R9 ie off no pend");
        exp_rd(1'b0, 32'h4000_0003, "R9 pend stays 0");

        // one-shot, period 2
        wr(1'b0, 32'hB000_0002);
        ticks(5);
        exp_rd(1'b1, 32'd2, "R7 oneshot stops");
        exp_irq(1'b1, "R7 oneshot pend");

        wr(1'b0, 32'hA000_0002);
        ticks(3);
        exp_rd(1'b1, 32'd2, "R4 same mode stays stopped");
        exp_irq(1'b0, "R10 clear on same mode");

        wr(1'b0, 32'hE000_0002);
        ticks(2);
        exp_rd(1'b1, 32'd4, "R3 change starts");
        exp_irq(1'b1, "R3 match after start");

        wr(1'b0, 32'h2000_0002);
        ticks(3);
        exp_rd(1'b1, 32'd4, "R3 off stops");
        exp_irq(1'b0, "R3 off cleared pend");

        wr(1'b1, 32'h0000_0010);
        wr(1'b0, 32'hE000_0010);
        ticks(1);
        exp_rd(1'b1, 32'h0000_0011, "R6 loaded value matches");
        exp_irq(1'b1, "R6 loaded match pend");

        wr(1'b1, 32'hF000_0007);
        wr(1'b0, 32'hE000_0007);
        ticks(1);
        exp_rd(1'b1, 32'hF000_0008, "R6 low bits compare");
        exp_irq(1'b1, "R6 low bits pend");

        wr(1'b0, 32'hC000_0005);
        wr(1'b1, 32'hFFFF_FFFF);
        ticks(1);
        exp_rd(1'b1, 32'h0, "R5 wrap to zero");
        exp_irq(1'b0, "R11 ie off low");
        exp_rd(1'b0, 32'hC000_0005, "R2 cfg readback");

        repeat (2) @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule